// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns one asynchronous serial line back into parallel characters. The line rests high. A falling edge marks a candidate start bit. The edge counts only if the line is still low at the next half-bit strobe; otherwise the receiver goes back to watching the idle line.

Once a start bit is confirmed, the receiver samples the line on every bit-rate strobe, which falls at the middle of each bit. It shifts the data bits in from the top of a register, so the first bit received ends in bit 0. It then checks an optional parity bit and one or two stop bits, and hands the finished character to the host together with parity and framing flags.

Both strobes come from an outside baud generator. The host takes a character by pulsing a read-acknowledge input. The serial input passes through a two-flop synchronizer before any logic looks at it. Parity and stop-bit settings are latched when a start bit is accepted, so they stay fixed for the whole character.

Top module: `async_char_rx`

## Requirements
- R1: After a synchronous reset, `char_out` is 0 and `char_valid`, `parity_fault`, `frame_fault` and `overrun` are all 0.
- R2: While the synchronized line stays high, neither strobe produces a character, and `char_valid` does not rise.
- R3: A low line becomes a start bit only if it is still low at the next `half_strobe`. If the line is high at that strobe, the receiver goes back to hunting and delivers no character.
- R4: After a confirmed start, the receiver samples `DATA_BITS` data bits, one at each `bit_strobe`. The first bit received appears in `char_out[0]` and the last in `char_out[DATA_BITS-1]`.
- R5: When `cfg_parity_on` = 1, the bit after the data is taken as parity. With `cfg_parity_odd` = 0 the data bits plus the parity bit must hold an even number of ones; with `cfg_parity_odd` = 1 they must hold an odd number. A mismatch sets `parity_fault` together with the character.
- R6: When `cfg_parity_on` = 0, no parity bit is sampled, the stop bit follows the data directly, and `parity_fault` is 0.
- R7: When `cfg_two_stop` = 0 there is one stop bit; when it is 1 there are two. A stop bit sampled as 0 sets `frame_fault`, and the character is still delivered.
- R8: `char_valid` goes to 1 two clock edges after the `bit_strobe` that samples the last stop bit. A `read_ack` pulse clears it at the next edge.
- R9: When a character completes while `char_valid` is still 1 and no `read_ack` is given, `overrun` is set and the new character replaces the old one. `read_ack` clears `overrun`.
- R10: `bit_strobe` is ignored while a start bit waits for confirmation, and `half_strobe` is ignored while data, parity or stop bits are being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| bit_strobe | input | 1 | One-cycle pulse at the middle of each bit period |
| half_strobe | input | 1 | One-cycle pulse half a bit time after a start edge |
| cfg_parity_on | input | 1 | 1 = a parity bit follows the data |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| read_ack | input | 1 | Host has taken the character |
| char_out | output | DATA_BITS | Last received character |
| char_valid | output | 1 | An unread character is held |
| parity_fault | output | 1 | Parity mismatch on the held character |
| frame_fault | output | 1 | A stop bit of the held character was 0 |
| overrun | output | 1 | A character was overwritten before it was read |

## Verification
The bench builds the receiver with `DATA_BITS` = 4. This makes it cheap to send every possible data value under each of the three parity settings (none, even, odd) and both stop-bit counts. On selected values it corrupts the parity bit, the first stop bit or the second stop bit. Every frame also carries stray strobes in the phases where they must be ignored, and an idle gap of strobes on a high line. Separate runs cover a start glitch that is rejected and a pair of characters that arrive without a read in between.

// File: rtl/async_char_rx_pkg.sv
package async_char_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_VERIFY = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } rx_state_t;

    typedef struct packed {
        logic parity_on;
        logic parity_odd;
        logic two_stop;
    } rx_cfg_t;

    typedef struct packed {
        logic par_bad;
        logic frm_bad;
    } rx_flags_t;

    // Returns 1 when the ones count of data plus parity bit breaks the rule
    function automatic logic parity_mismatch(input logic data_xor,
                                             input logic par_bit,
                                             input logic odd_mode);
        return (data_xor ^ par_bit) != odd_mode;
    endfunction

    function automatic logic [1:0] stop_count(input logic two_stop);
        return two_stop ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/async_char_rx_sync.sv
module async_char_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/async_char_rx_bitcnt.sv
module async_char_rx_bitcnt #(
    parameter int MAX_COUNT = 8,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          at_last
);
    always_ff @(posedge clk) begin
        if (rst)                   count <= '0;
        else if (load)             count <= load_val;
        else if (dec && count != 0) count <= count - 1'b1;
    end

    assign at_last = (count == CW'(1));
endmodule

// File: rtl/async_char_rx_frame.sv
module async_char_rx_frame
    import async_char_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    localparam int CW = $clog2(DATA_BITS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_s,
    input  logic                 bit_strobe,
    input  logic                 half_strobe,
    input  rx_cfg_t              cfg_in,
    output logic                 done,
    output logic [DATA_BITS-1:0] shift_q,
    output rx_flags_t            flags_q
);
    rx_state_t     state;
    rx_cfg_t       cfg_q;
    logic          cnt_load, cnt_dec, cnt_last;
    logic [CW-1:0] cnt_val, cnt_q;

    async_char_rx_bitcnt #(.MAX_COUNT(DATA_BITS)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .count(cnt_q), .at_last(cnt_last)
    );

    always_comb begin
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_VERIFY: if (half_strobe && !line_s) begin
                cnt_load = 1'b1;
                cnt_val  = CW'(DATA_BITS);
            end
            ST_DATA: if (bit_strobe) begin
                if (cnt_last && !cfg_q.parity_on) begin
                    cnt_load = 1'b1;
                    cnt_val  = CW'(stop_count(cfg_q.two_stop));
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_PARITY: if (bit_strobe) begin
                cnt_load = 1'b1;
                cnt_val  = CW'(stop_count(cfg_q.two_stop));
            end
            ST_STOP: if (bit_strobe) cnt_dec = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            cfg_q   <= '0;
            shift_q <= '0;
            flags_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_HUNT: if (!line_s) state <= ST_VERIFY;
                ST_VERIFY: if (half_strobe) begin
                    if (!line_s) begin
                        state   <= ST_DATA;
                        cfg_q   <= cfg_in;
                        flags_q <= '0;
                    end else begin
                        state <= ST_HUNT;
                    end
                end
                ST_DATA: if (bit_strobe) begin
                    shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
                    if (cnt_last) state <= cfg_q.parity_on ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: if (bit_strobe) begin
                    flags_q.par_bad <= parity_mismatch(^shift_q, line_s, cfg_q.parity_odd);
                    state <= ST_STOP;
                end
                ST_STOP: if (bit_strobe) begin
                    if (!line_s) flags_q.frm_bad <= 1'b1;
                    if (cnt_last) begin
                        done  <= 1'b1;
                        state <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // R2
    hunt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && line_s) |=> (state == ST_HUNT));
    // R3
    start_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VERIFY && half_strobe && line_s) |=> (state == ST_HUNT && !done));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DATA_BITS));
    // R10
    half_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && half_strobe && !bit_strobe) |=> $stable(shift_q));
    // R6
    no_parity_state_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARITY) |-> cfg_q.parity_on);
endmodule

// File: rtl/async_char_rx_hold.sv
module async_char_rx_hold
    import async_char_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data_in,
    input  rx_flags_t            flags_in,
    input  logic                 read_ack,
    output logic [DATA_BITS-1:0] data_q,
    output rx_flags_t            flags_q,
    output logic                 valid_q,
    output logic                 overrun_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            flags_q   <= '0;
            valid_q   <= 1'b0;
            overrun_q <= 1'b0;
        end else if (done) begin
            data_q    <= data_in;
            flags_q   <= flags_in;
            valid_q   <= 1'b1;
            overrun_q <= !read_ack && (valid_q || overrun_q);
        end else if (read_ack) begin
            valid_q   <= 1'b0;
            overrun_q <= 1'b0;
        end
    end

    // R8
    valid_set_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> valid_q);
    // R8
    valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (read_ack && !done) |=> !valid_q);
    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done && valid_q && !read_ack) |=> overrun_q);
    // R9
    overrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (read_ack && !done) |=> !overrun_q);
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_char_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 serial_in,
    input  logic                 bit_strobe,
    input  logic                 half_strobe,
    input  logic                 cfg_parity_on,
    input  logic                 cfg_parity_odd,
    input  logic                 cfg_two_stop,
    input  logic                 read_ack,
    output logic [DATA_BITS-1:0] char_out,
    output logic                 char_valid,
    output logic                 parity_fault,
    output logic                 frame_fault,
    output logic                 overrun
);
    logic                 line_s;
    logic                 frame_done;
    logic [DATA_BITS-1:0] frame_data;
    rx_flags_t            frame_flags, held_flags;
    rx_cfg_t              cfg;

    assign cfg = '{parity_on: cfg_parity_on, parity_odd: cfg_parity_odd,
                   two_stop: cfg_two_stop};

    async_char_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(serial_in), .dout(line_s)
    );

    async_char_rx_frame #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk(clk), .rst(rst), .line_s(line_s), .bit_strobe(bit_strobe),
        .half_strobe(half_strobe), .cfg_in(cfg), .done(frame_done),
        .shift_q(frame_data), .flags_q(frame_flags)
    );

    async_char_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk(clk), .rst(rst), .done(frame_done), .data_in(frame_data),
        .flags_in(frame_flags), .read_ack(read_ack), .data_q(char_out),
        .flags_q(held_flags), .valid_q(char_valid), .overrun_q(overrun)
    );

    assign parity_fault = held_flags.par_bad;
    assign frame_fault  = held_flags.frm_bad;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!char_valid && !overrun && !parity_fault && !frame_fault));
endmodule

// File: tb/async_char_rx_tb.sv
module async_char_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_DW      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic serial_in = 1'b1, bit_strobe = 1'b0, half_strobe = 1'b0;
    logic cfg_parity_on = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
    logic read_ack = 1'b0;
    logic [TB_DW-1:0] char_out;
    logic char_valid, parity_fault, frame_fault, overrun;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_char_rx #(.DATA_BITS(TB_DW)) u_dut (
        .clk(clk), .rst(rst), .serial_in(serial_in), .bit_strobe(bit_strobe),
        .half_strobe(half_strobe), .cfg_parity_on(cfg_parity_on),
        .cfg_parity_odd(cfg_parity_odd), .cfg_two_stop(cfg_two_stop),
        .read_ack(read_ack), .char_out(char_out), .char_valid(char_valid),
        .parity_fault(parity_fault), .frame_fault(frame_fault), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_half();
        half_strobe = 1'b1; @(negedge clk); half_strobe = 1'b0;
    endtask

    task automatic pulse_bit();
        bit_strobe = 1'b1; @(negedge clk); bit_strobe = 1'b0;
    endtask

    // one bit period: stray half strobe (R10), then a mid-bit sample
    task automatic bit_slot(input logic v);
        serial_in = v;
        repeat (2) @(negedge clk);
        pulse_half();
        pulse_bit();
        repeat (2) @(negedge clk);
    endtask

    // line high, both strobes: nothing may start (R2)
    task automatic idle_gap();
        serial_in = 1'b1;
        repeat (3) @(negedge clk);
        pulse_half();
        pulse_bit();
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input logic [TB_DW-1:0] d, input int mode,
                              input logic two, input logic bad_par,
                              input logic bad_s1, input logic bad_s2);
        cfg_parity_on  = (mode != 0);
        cfg_parity_odd = (mode == 2);
        cfg_two_stop   = two;
        serial_in = 1'b0;
        repeat (3) @(negedge clk);
        pulse_bit();           // R10: ignored while start awaits confirmation
        pulse_half();
        @(negedge clk);
        for (int i = 0; i < TB_DW; i++) bit_slot(d[i]);
        if (mode != 0) bit_slot((^d) ^ (mode == 2) ^ bad_par);
        bit_slot(!bad_s1);
        if (two) bit_slot(!bad_s2);
        idle_gap();
    endtask

    task automatic ack();
        read_ack = 1'b1; @(negedge clk); read_ack = 1'b0; @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 char_out", int'(char_out), 0);
        chk("R1 char_valid", int'(char_valid), 0);
        chk("R1 flags", int'({parity_fault, frame_fault, overrun}), 0);

        // R2 idle line with strobes
        idle_gap();
        idle_gap();
        chk("R2 no char on idle", int'(char_valid), 0);

        // R3 start glitch rejected
        serial_in = 1'b0;
        repeat (4) @(negedge clk);
        serial_in = 1'b1;
        repeat (4) @(negedge clk);
        pulse_half();
        repeat (4) @(negedge clk);
        pulse_bit();
        repeat (4) @(negedge clk);
        chk("R3 glitch gives no char", int'(char_valid), 0);
        send_frame(4'hA, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 frame after glitch", int'(char_out), 'hA);
        chk("R3 valid after glitch", int'(char_valid), 1);
        ack();

        // Sweep: every value, every parity mode, both stop counts
        for (int d = 0; d < (1 << TB_DW); d++) begin
            for (int mode = 0; mode < 3; mode++) begin
                for (int two = 0; two < 2; two++) begin
                    logic bp, b1, b2;
                    bp = (mode != 0) && (d % 5 == 0);
                    b1 = (d % 7 == 3);
                    b2 = (two == 1) && (d % 7 == 5);
                    send_frame(TB_DW'(d), mode, two[0], bp, b1, b2);
                    // R4 LSB-first data
                    chk("R4 data", int'(char_out), d);
                    // R8 valid after completion
                    chk("R8 valid set", int'(char_valid), 1);
                    // R5 / R6 parity flag
                    if (mode == 0) chk("R6 parity off", int'(parity_fault), 0);
                    else chk("R5 parity flag", int'(parity_fault), int'(bp));
                    // R7 framing flag, char still delivered
                    chk("R7 frame flag", int'(frame_fault), int'(b1 | b2));
                    chk("R9 no overrun", int'(overrun), 0);
                    ack();
                    chk("R8 valid cleared", int'(char_valid), 0);
                end
            end
        end

        // R9 overrun: two chars without a read
        send_frame(4'h3, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(4'hC, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 overrun set", int'(overrun), 1);
        chk("R9 newer char kept", int'(char_out), 'hC);
        chk("R9 valid held", int'(char_valid), 1);
        ack();
        chk("R9 overrun cleared", int'(overrun), 0);
        chk("R8 valid cleared after overrun", int'(char_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule